// File: doc/BRIEF.md
# Progressive Composite Video Timing Generator

This block produces the raster timing for a black-and-white CRT that is driven from a composite signal. It runs from one 16 MHz clock. Internally it keeps two counters. The first is a clock counter that spans one scan line; its upper bits form the dot position. The second is a line counter that spans one frame. The decode of these two counters gives horizontal and vertical blanking and sync windows. These windows combine into one composite blank flag, one composite sync flag and an active-picture flag. A bar-like test pattern is drawn inside the picture area, and a 2-bit level code tells an external DAC whether to output the sync tip, black or white.

The frame is progressive. It has 312 lines, and each line lasts 1024 clocks (64 µs), which gives roughly 50.08 frames per second. Every frame has the same layout. Vertical sync is a plain run of whole lines: there are no half lines, equalizing pulses or field alternation. The block also brings out the current dot and line coordinates. It provides start-of-line and start-of-frame strobes so that an external pixel source can stay in step with the raster. All outputs come from registers that share one clock edge, so they are free of decode glitches. The block has no data stream and therefore no handshake.

Top module: `crt_sync_gen`

## Requirements
- R1: A synchronous active-high reset clears both counters. In the first cycle after the last reset edge, the outputs show dot 0 of line 0 with active high, blank and sync low, and sol and sof high.
- R2: Each dot lasts two clocks. The dot coordinate equals the clock count within the line divided by two. A line is 1024 clocks, or 512 dots, and the dot coordinate wraps from 511 to 0.
- R3: Within a line, dots 0 to 383 lie outside horizontal blanking. Dots 384 to 415 are blank without sync. Dots 416 to 447 are blank with sync. Dots 448 to 511 are blank without sync.
- R4: The line coordinate advances only in the cycle that follows clock count 1023 of a line. It counts 0 to 311 and then returns to 0.
- R5: Within a frame, lines 0 to 287 lie outside vertical blanking. Lines 288 to 291 are blank without sync. Lines 292 to 295 are blank with sync. Lines 296 to 311 are blank without sync.
- R6: sync is the OR of the horizontal and vertical sync windows. blank is the OR of the two blanking windows. active is high exactly when blank is low.
- R7: A pixel is white when all three of these hold: active is high, the low four bits of the clock count within the line are all ones (count mod 16 = 15), and bit 3 of the line coordinate is 1.
- R8: The level code is 2'b00 while sync is high. It is 2'b10 for a white pixel. It is 2'b01 in every other case (blank or black).
- R9: The dot, line, flags, level code and strobes all refer to the same counter state in every cycle, and they all update on the same clock edge.
- R10: sol is high for exactly one clock per line, in the cycle where the clock count is 0. sof is high only when sol is high and the line coordinate is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 16 MHz pixel-timing clock |
| rst | input | 1 | Synchronous active-high reset |
| level | output | 2 | Composite level code: 00 sync, 01 blank/black, 10 white |
| blank | output | 1 | Composite blanking flag |
| sync | output | 1 | Composite sync flag |
| active | output | 1 | Active-picture flag |
| dot_x | output | 9 | Current dot within the line |
| line_y | output | 9 | Current line within the frame |
| sol | output | 1 | Start-of-line strobe |
| sof | output | 1 | Start-of-frame strobe |

## Verification
The vertical sync lines and the return from line 311 to line 0 are the conditions that are hardest to reach. With the default sizes they come only after about 300,000 clocks. To reach them, the bench builds a second instance that keeps the same structure but has a 64-clock line and a 20-line frame. That instance is swept cycle by cycle over more than two complete frames, so every vertical region and the frame wrap are visited several times. A full-size instance is swept over its first few lines to check the horizontal boundaries at their real positions. A reset applied in the middle of a line confirms that the counters restart from any state.

// File: rtl/crt_sync_pkg.sv
package crt_sync_pkg;
  typedef enum logic [1:0] {
    LVL_SYNC  = 2'b00,
    LVL_BLACK = 2'b01,
    LVL_WHITE = 2'b10
  } level_e;
endpackage

// File: rtl/crt_raster_cnt.sv
module crt_raster_cnt #(
  parameter int CLK_W  = 10,
  parameter int LINE_W = 9,
  parameter int LINES  = 312
) (
  input  logic              clk,
  input  logic              rst,
  output logic [CLK_W-1:0]  nxt_clk,
  output logic [LINE_W-1:0] nxt_line
);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES - 1);

  logic [CLK_W-1:0]  clk_q;
  logic [LINE_W-1:0] line_q;
  logic              wrap;

  assign wrap = (clk_q == {CLK_W{1'b1}});

  always_comb begin
    if (rst) begin
      nxt_clk  = '0;
      nxt_line = '0;
    end else begin
      nxt_clk  = clk_q + 1'b1;
      nxt_line = line_q;
      if (wrap) nxt_line = (line_q == LAST_LINE) ? '0 : line_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    clk_q  <= nxt_clk;
    line_q <= nxt_line;
  end
endmodule

// File: rtl/crt_span_dec.sv
module crt_span_dec #(
  parameter int W      = 9,
  parameter int ACTIVE = 384,
  parameter int FRONT  = 32,
  parameter int SYNC   = 32
) (
  input  logic [W-1:0] pos,
  output logic         blank,
  output logic         sync
);
  localparam int SYNC_LO = ACTIVE + FRONT;
  localparam int SYNC_HI = SYNC_LO + SYNC;

  int p;
  assign p     = 32'(pos);
  assign blank = (p >= ACTIVE);
  assign sync  = (p >= SYNC_LO) && (p < SYNC_HI);
endmodule

// File: rtl/crt_sync_gen.sv
module crt_sync_gen
  import crt_sync_pkg::*;
#(
  parameter int DOT_W        = 9,
  parameter int H_ACTIVE     = 384,
  parameter int H_FRONT      = 32,
  parameter int H_SYNC       = 32,
  parameter int LINES        = 312,
  parameter int V_ACTIVE     = 288,
  parameter int V_FRONT      = 4,
  parameter int V_SYNC       = 4,
  parameter int PAT_LINE_BIT = 3,
  parameter int LINE_W       = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  output logic [1:0]        level,
  output logic              blank,
  output logic              sync,
  output logic              active,
  output logic [DOT_W-1:0]  dot_x,
  output logic [LINE_W-1:0] line_y,
  output logic              sol,
  output logic              sof
);
  localparam int CLK_W = DOT_W + 1;

  logic [CLK_W-1:0]  nxt_clk;
  logic [LINE_W-1:0] nxt_line;
  logic [DOT_W-1:0]  nxt_dot;
  logic h_blank, h_sync, v_blank, v_sync;
  logic d_blank, d_sync, d_white, d_sol;
  level_e d_level;

  crt_raster_cnt #(.CLK_W(CLK_W), .LINE_W(LINE_W), .LINES(LINES)) u_cnt (
    .clk(clk), .rst(rst), .nxt_clk(nxt_clk), .nxt_line(nxt_line)
  );

  assign nxt_dot = nxt_clk[CLK_W-1:1];

  crt_span_dec #(.W(DOT_W), .ACTIVE(H_ACTIVE), .FRONT(H_FRONT), .SYNC(H_SYNC)) u_hdec (
    .pos(nxt_dot), .blank(h_blank), .sync(h_sync)
  );

  crt_span_dec #(.W(LINE_W), .ACTIVE(V_ACTIVE), .FRONT(V_FRONT), .SYNC(V_SYNC)) u_vdec (
    .pos(nxt_line), .blank(v_blank), .sync(v_sync)
  );

  always_comb begin
    d_blank = h_blank | v_blank;
    d_sync  = h_sync | v_sync;
    d_white = !d_blank && (&nxt_clk[3:0]) && nxt_line[PAT_LINE_BIT];
    d_sol   = (nxt_clk == '0);
    if (d_sync)       d_level = LVL_SYNC;
    else if (d_white) d_level = LVL_WHITE;
    else              d_level = LVL_BLACK;
  end

  always_ff @(posedge clk) begin
    level  <= d_level;
    blank  <= d_blank;
    sync   <= d_sync;
    active <= !d_blank;
    dot_x  <= nxt_dot;
    line_y <= nxt_line;
    sol    <= d_sol;
    sof    <= d_sol && (nxt_line == '0);
  end
endmodule

// File: rtl/crt_sync_gen_chk.sv
module crt_sync_gen_chk #(
  parameter int DOT_W  = 9,
  parameter int LINE_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        level,
  input logic              blank,
  input logic              sync,
  input logic              active,
  input logic [DOT_W-1:0]  dot_x,
  input logic [LINE_W-1:0] line_y,
  input logic              sol,
  input logic              sof
);
  // R6
  sync_in_blank_chk: assert property (@(posedge clk) disable iff (rst) sync |-> blank);
  // R8
  sync_level_chk: assert property (@(posedge clk) disable iff (rst) sync |-> level == 2'b00);
  // R7
  white_active_chk: assert property (@(posedge clk) disable iff (rst)
    (level == 2'b10) |-> (active && !blank && !sync));
  // R10
  frame_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    sof |-> (sol && dot_x == '0 && line_y == '0));
  // R10
  line_strobe_once_chk: assert property (@(posedge clk) disable iff (rst) sol |=> !sol);
  // R4
  line_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(line_y) |-> ($past(dot_x) == {DOT_W{1'b1}}));
  // R2
  dot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(dot_x) |=> $stable(dot_x));
endmodule

bind crt_sync_gen crt_sync_gen_chk #(.DOT_W(DOT_W), .LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst(rst), .level(level), .blank(blank), .sync(sync), .active(active),
  .dot_x(dot_x), .line_y(line_y), .sol(sol), .sof(sof)
);

// File: tb/crt_sync_gen_bench.sv
module crt_sync_gen_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  always #5 clk = ~clk;

  // full-size instance
  logic [1:0] b_level; logic b_blank, b_sync, b_active, b_sol, b_sof;
  logic [8:0] b_dot; logic [8:0] b_line;
  crt_sync_gen u_crt_sync_gen (
    .clk(clk), .rst(rst), .level(b_level), .blank(b_blank), .sync(b_sync),
    .active(b_active), .dot_x(b_dot), .line_y(b_line), .sol(b_sol), .sof(b_sof)
  );

  // reduced instance: 32 dots x 20 lines
  logic [1:0] s_level; logic s_blank, s_sync, s_active, s_sol, s_sof;
  logic [4:0] s_dot; logic [4:0] s_line;
  crt_sync_gen #(.DOT_W(5), .H_ACTIVE(20), .H_FRONT(4), .H_SYNC(4),
                 .LINES(20), .V_ACTIVE(14), .V_FRONT(2), .V_SYNC(2)) u_small (
    .clk(clk), .rst(rst), .level(s_level), .blank(s_blank), .sync(s_sync),
    .active(s_active), .dot_x(s_dot), .line_y(s_line), .sol(s_sol), .sof(s_sof)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  // expected outputs for k cycles after the last reset edge
  task automatic check_state(input string who, input int k, input int cpl, input int ha,
                             input int hf, input int hs, input int nl, input int va,
                             input int vf, input int vs, input int lvl, input int bl,
                             input int sy, input int act, input int dx, input int ly,
                             input int sl, input int sf);
    int ci, dot, ln, hb, hsy, vb, vsy, e_bl, e_sy, e_act, white, e_lvl;
    ci  = k % cpl;
    dot = ci / 2;
    ln  = (k / cpl) % nl;
    hb  = int'(dot >= ha);
    hsy = int'(dot >= ha + hf && dot < ha + hf + hs);
    vb  = int'(ln >= va);
    vsy = int'(ln >= va + vf && ln < va + vf + vs);
    e_bl  = hb | vb;
    e_sy  = hsy | vsy;
    e_act = 1 - e_bl;
    white = int'(e_act == 1 && (ci % 16) == 15 && ((ln / 8) % 2) == 1);
    e_lvl = e_sy ? 0 : (white ? 2 : 1);
    chk({who, " R2 dot"}, dx, dot);
    chk({who, " R4 line"}, ly, ln);
    chk({who, " R3/R5/R6 blank"}, bl, e_bl);
    chk({who, " R3/R5/R6 sync"}, sy, e_sy);
    chk({who, " R6 active"}, act, e_act);
    chk({who, " R7/R8 level"}, lvl, e_lvl);
    chk({who, " R10 sol"}, sl, int'(ci == 0));
    chk({who, " R10 sof"}, sf, int'(ci == 0 && ln == 0));
  endtask

  task automatic check_small(input int k);
    check_state("small", k, 64, 20, 4, 4, 20, 14, 2, 2, int'(s_level), int'(s_blank),
                int'(s_sync), int'(s_active), int'(s_dot), int'(s_line), int'(s_sol), int'(s_sof));
  endtask

  task automatic check_big(input int k);
    check_state("full", k, 1024, 384, 32, 32, 312, 288, 4, 4, int'(b_level), int'(b_blank),
                int'(b_sync), int'(b_active), int'(b_dot), int'(b_line), int'(b_sol), int'(b_sof));
  endtask

  initial begin
    // R1: reset state, both instances
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset dot", int'(b_dot), 0);
    chk("R1 reset line", int'(b_line), 0);
    chk("R1 reset active", int'(b_active), 1);
    chk("R1 reset sof", int'(b_sof), 1);
    check_small(0);
    check_big(0);
    rst = 1'b0;
    // R9: every output compared in the same sampled cycle
    for (int k = 1; k <= 3300; k++) begin
      @(negedge clk);
      check_small(k);
      if (k <= 3200) check_big(k);
    end
    // R1: reset in the middle of a line, held two edges
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check_small(0);
    check_big(0);
    rst = 1'b0;
    for (int k = 1; k <= 200; k++) begin
      @(negedge clk);
      check_small(k);
      check_big(k);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule